// File: doc/BRIEF.md
# Dual-Channel Serial DAC Frame Writer

This block takes an 8-bit output code and a channel choice from the surrounding logic and sends them to a two-channel, 8-bit, voltage-output DAC over a three-wire serial link. The link has an active-low frame strobe, a serial clock and a data line. For every accepted sample the block builds a 16-bit frame. An 8-bit control byte comes first and carries the channel choice and the update behaviour. The sample byte follows. The block shifts the frame out MSB first and then raises `ready_o` again. The converter's output is 2·VREF·N/256 for code N; the analog stage is outside this block.

The serial clock comes from the system clock through a half-period divider (`HALF_DIV` system cycles per half period). At 125 MHz the default of 3 gives about 20.8 MHz, below the converter's 30 MHz limit; a value of 2 would exceed it. A frame has a lead phase, 16 clock periods and a trail phase, each phase lasting `HALF_DIV` cycles. This is 34·`HALF_DIV` cycles in total, about 0.8 µs with the defaults.

The controller has five states. `ST_IDLE` waits for a load. `ST_LEAD` pulls the strobe low with the clock high and bit 15 on the data line. `ST_CLK_LO` and `ST_CLK_HI` are the two halves of one serial clock period. `ST_TRAIL` has the strobe high and waits before `ready_o` returns. The transitions are:
- T_ACCEPT: `ST_IDLE` to `ST_LEAD` when a load is present.
- T_START: `ST_LEAD` to `ST_CLK_LO` at the end of the phase.
- T_RISE: `ST_CLK_LO` to `ST_CLK_HI` at the end of the phase.
- T_NEXT: `ST_CLK_HI` to `ST_CLK_LO` when bits remain. The data line moves to the next bit.
- T_END: `ST_CLK_HI` to `ST_TRAIL` after the sixteenth bit.
- T_DONE: `ST_TRAIL` to `ST_IDLE` at the end of the phase.

Top module: `dac_frame_writer`

## Requirements
- R1: While reset is asserted and after it is released with no load, `ready_o`=1, `sync_n_o`=1, `sclk_o`=1 and `sdin_o`=0.
- R2: A load sampled on a clock edge while `ready_o`=1 is accepted. From the next cycle, `ready_o`=0 and `sync_n_o`=0.
- R3: The frame is 16 bits, sent MSB first: the control byte and then the data byte. With the default parameters the control byte is 0x03 for channel 0 and 0x07 for channel 1. Bit 2 is the channel select, bits 1:0 = 11 select immediate update, and all other bits are 0.
- R4: Every low and every high half of the serial clock lasts `HALF_DIV` system cycles. Each frame has exactly 16 rising edges of `sclk_o`.
- R5: `sdin_o` changes only when `sclk_o` falls, or when a frame opens or closes. It is stable while `sclk_o` is high inside a frame.
- R6: `sync_n_o` stays low for 33·`HALF_DIV` cycles per frame: a lead of `HALF_DIV` cycles, then 16 clock periods.
- R7: `ready_o` returns `HALF_DIV` cycles after `sync_n_o` rises, so a frame keeps the block busy for 34·`HALF_DIV` cycles.
- R8: A load while `ready_o`=0 is ignored. The current frame is unchanged and no extra frame is sent.
- R9: If the load is held high, the next frame is accepted in the first cycle that `ready_o` is high. `sync_n_o` then stays high for `HALF_DIV`+1 cycles between frames.
- R10: Outside frames, `sclk_o` rests high and `sdin_o` rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Request to send the presented sample |
| chan_i | input | 1 | Target channel (0 or 1) |
| data_i | input | DATA_W | Output code for the converter |
| ready_o | output | 1 | High when a load will be accepted |
| sync_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock, rests high |
| sdin_o | output | 1 | Serial data, valid on rising `sclk_o` |

## Verification
A rejected load and an accepted load can fall on adjacent edges. In the last `ST_TRAIL` cycle a load is still ignored. One cycle later, in `ST_IDLE`, the same load is taken. The bench provokes this by holding `load_i` high across several frames and by pulsing it in the middle of a frame. A behavioural reference model, built from frame timing (a cycle count and a bit queue), predicts every pin on every cycle, and the bench compares against it. It also measures the strobe-high gap between back-to-back frames and compares the number of frames seen with the number the model accepted.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_TRAIL
    } dacw_state_e;

    // Control byte: reference choice at the top bit, channel at chan_pos,
    // update mode at the two lowest bits, everything else zero.
    function automatic logic [CTRL_W-1:0] dacw_ctrl_byte(
        input logic       ref_ext,
        input logic       chan,
        input int         chan_pos,
        input logic [1:0] upd_mode
    );
        logic [CTRL_W-1:0] b;
        b = '0;
        b[CTRL_W-1] = ref_ext;
        b[chan_pos] = chan;
        b[1:0]      = upd_mode;
        return b;
    endfunction

endpackage

// File: rtl/dacw_pacer.sv
module dacw_pacer #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_every_cycle
            assign tick_o = 1'b1;
        end else begin : g_counted
            logic [CNT_W-1:0] cnt_q;

            assign tick_o = (cnt_q == CNT_W'(HALF_DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear_i || tick_o) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    assign msb_o  = word_q[WORD_W-1];
    assign last_o = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            idx_q  <= IDX_W'(WORD_W - 1);
        end else if (shift_i) begin
            // the final shift flushes the word to zero for the idle level
            word_q <= {word_q[WORD_W-2:0], 1'b0};
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dacw_fsm.sv
module dacw_fsm
    import dacw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    input  logic last_i,
    output logic accept_o,
    output logic shift_o,
    output logic clear_o,
    output logic ready_o,
    output logic sync_n_o,
    output logic sclk_o
);

    dacw_state_e state_q;
    dacw_state_e state_d;

    assign accept_o = (state_q == ST_IDLE) && load_i;
    assign shift_o  = (state_q == ST_CLK_HI) && tick_i;
    assign clear_o  = (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_i) state_d = ST_LEAD;
            ST_LEAD:   if (tick_i) state_d = ST_CLK_LO;
            ST_CLK_LO: if (tick_i) state_d = ST_CLK_HI;
            ST_CLK_HI: if (tick_i) state_d = last_i ? ST_TRAIL : ST_CLK_LO;
            ST_TRAIL:  if (tick_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pin levels registered from the next state: same timing as the
    // state register, without decode glitches on the pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_o  <= 1'b1;
            sync_n_o <= 1'b1;
            sclk_o   <= 1'b1;
        end else begin
            ready_o  <= (state_d == ST_IDLE);
            sync_n_o <= (state_d == ST_IDLE) || (state_d == ST_TRAIL);
            sclk_o   <= (state_d != ST_CLK_LO);
        end
    end

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer #(
    parameter int         HALF_DIV = 3,
    parameter int         DATA_W   = 8,
    parameter int         CHAN_POS = 2,
    parameter logic [1:0] UPD_MODE = 2'b11,
    parameter logic       REF_EXT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              chan_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic              sync_n_o,
    output logic              sclk_o,
    output logic              sdin_o
);

    import dacw_pkg::*;

    localparam int WORD_W = CTRL_W + DATA_W;

    logic              accept;
    logic              shift;
    logic              clear;
    logic              tick;
    logic              last;
    logic [WORD_W-1:0] frame_word;

    assign frame_word = {dacw_ctrl_byte(REF_EXT, chan_i, CHAN_POS, UPD_MODE), data_i};

    dacw_pacer #(
        .HALF_DIV (HALF_DIV)
    ) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tick_o  (tick)
    );

    dacw_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .word_i  (frame_word),
        .shift_i (shift),
        .msb_o   (sdin_o),
        .last_o  (last)
    );

    dacw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .tick_i   (tick),
        .last_i   (last),
        .accept_o (accept),
        .shift_o  (shift),
        .clear_o  (clear),
        .ready_o  (ready_o),
        .sync_n_o (sync_n_o),
        .sclk_o   (sclk_o)
    );

endmodule

// File: rtl/dacw_checker.sv
module dacw_checker #(
    parameter int HALF_DIV = 3
) (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic ready_o,
    input logic sync_n_o,
    input logic sclk_o,
    input logic sdin_o
);

    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;
    logic [5:0]  rise_cnt;
    logic        sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            hi_cnt   <= '0;
            rise_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_o;
            lo_cnt <= sclk_o ? 16'd0 : lo_cnt + 16'd1;
            hi_cnt <= (sclk_o && !sync_n_o) ? hi_cnt + 16'd1 : 16'd0;
            if (sync_n_o) begin
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_d) begin
                rise_cnt <= rise_cnt + 6'd1;
            end
        end
    end

    // R1
    a_r1_reset_levels: assert property (@(posedge clk)
        !rst_n |=> (ready_o && sync_n_o && sclk_o && !sdin_o));

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && load_i) |=> (!ready_o && !sync_n_o));

    // R4: low half length
    a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_cnt == 16'(HALF_DIV)));

    // R4: high half length inside a frame
    a_r4_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_cnt == 16'(HALF_DIV)));

    // R4: sixteen rising edges per frame
    a_r4_edges_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> (rise_cnt == 6'd16));

    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o) && !sync_n_o && !$past(sync_n_o)) |-> $stable(sdin_o));

    a_r7_ready_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n_o) |=> !ready_o);

    a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (sclk_o && !sdin_o && sync_n_o));

endmodule

bind dac_frame_writer dacw_checker #(
    .HALF_DIV (HALF_DIV)
) i_dacw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .ready_o  (ready_o),
    .sync_n_o (sync_n_o),
    .sclk_o   (sclk_o),
    .sdin_o   (sdin_o)
);

// File: tb/test_dac_frame_writer.sv
module test_dac_frame_writer;

    localparam int H     = 3;
    localparam int FRAME = 34 * H;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       chan_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       ready_o;
    logic       sync_n_o;
    logic       sclk_o;
    logic       sdin_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // reference model state
    bit   m_busy = 1'b0;
    int   m_t = 0;
    logic m_bits[$];
    int   frames_exp = 0;

    // monitor state
    int   frames_seen = 0;
    int   high_run = 0;
    int   last_gap = 0;
    int   rises = 0;
    logic prev_sync = 1'b1;
    logic prev_sclk = 1'b1;

    always #4 clk = ~clk;

    dac_frame_writer #(.HALF_DIV(H)) i_dac_frame_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .chan_i   (chan_i),
        .data_i   (data_i),
        .ready_o  (ready_o),
        .sync_n_o (sync_n_o),
        .sclk_o   (sclk_o),
        .sdin_o   (sdin_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // model: advances on each edge from the values sampled there
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == FRAME) m_busy = 1'b0;
        end else if (load_i) begin
            logic [7:0] ctrl;
            ctrl = chan_i ? 8'h07 : 8'h03;
            m_bits = {};
            for (int i = 7; i >= 0; i--) m_bits.push_back(ctrl[i]);
            for (int i = 7; i >= 0; i--) m_bits.push_back(data_i[i]);
            m_busy = 1'b1;
            m_t = 0;
            frames_exp++;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic er, es, ec, ed;
            int ph;
            er = 1'b1; es = 1'b1; ec = 1'b1; ed = 1'b0;
            if (m_busy) begin
                ph = m_t / H;
                er = 1'b0;
                if (ph == 0) begin
                    es = 1'b0; ec = 1'b1; ed = m_bits[0];
                end else if (ph <= 32) begin
                    es = 1'b0; ec = ((ph - 1) % 2 == 1); ed = m_bits[(ph - 1) / 2];
                end else begin
                    es = 1'b1; ec = 1'b1; ed = 1'b0;
                end
            end
            check(ready_o === er, "R2 R7 R8 R9 ready", int'(ready_o), int'(er));
            check(sync_n_o === es, "R6 sync", int'(sync_n_o), int'(es));
            check(sclk_o === ec, "R4 R10 sclk", int'(sclk_o), int'(ec));
            check(sdin_o === ed, "R3 R5 R10 sdin", int'(sdin_o), int'(ed));

            // frame monitor
            if (!sync_n_o && sclk_o && !prev_sclk) rises++;
            if (prev_sync && !sync_n_o) begin
                frames_seen++;
                last_gap = high_run;
            end
            if (!prev_sync && sync_n_o) begin
                check(rises == 16, "R4 rising edges per frame", rises, 16);
                rises = 0;
            end
            high_run = sync_n_o ? high_run + 1 : 0;
            prev_sync = sync_n_o;
            prev_sclk = sclk_o;
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic ch, input logic [7:0] d);
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        load_i = 1'b1; chan_i = ch; data_i = d;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 levels during reset
        check(ready_o === 1'b1, "R1 ready", int'(ready_o), 1);
        check(sync_n_o === 1'b1, "R1 sync", int'(sync_n_o), 1);
        check(sclk_o === 1'b1, "R1 sclk", int'(sclk_o), 1);
        check(sdin_o === 1'b0, "R1 sdin", int'(sdin_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        send(1'b0, 8'hA5);           // R3 channel 0, mixed bits
        wait_idle();
        send(1'b1, 8'h3C);           // R3 channel 1
        repeat (20) @(negedge clk);
        load_i = 1'b1; chan_i = 1'b0; data_i = 8'hFF;   // R8 ignored mid-frame
        @(negedge clk);
        load_i = 1'b0;
        wait_idle();
        send(1'b1, 8'hFF);           // all-ones boundary
        wait_idle();
        send(1'b0, 8'h00);           // all-zeros boundary
        wait_idle();

        // R9: load held across frame ends
        @(negedge clk);
        load_i = 1'b1; chan_i = 1'b1; data_i = 8'h81;
        repeat (3 * FRAME + 20) @(negedge clk);
        load_i = 1'b0;
        check(last_gap == H + 1, "R9 strobe-high gap", last_gap, H + 1);
        wait_idle();

        check(frames_seen == frames_exp, "R8 frame count", frames_seen, frames_exp);
        check(frames_exp == 8, "R8 R9 accepted frames", frames_exp, 8);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule